// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Flag Update

This block performs the single-bit shifts and rotates of a small 8-bit processor on one byte, together with the two nibble exchanges between the accumulator and a byte in memory. Each operation returns the new byte and a new flag byte. A separate input decides whether the sign, zero and parity flags are recomputed or kept.

An operation on a register operand is started with `start`. Its result, flags and `done` appear one cycle later. An operation on a memory operand is started in the same way with `mem_mode` set. The nibble exchanges always take this path. The unit then issues one read request and holds it until acknowledged. Next it issues one write request carrying the result and holds it until acknowledged. Finally it pulses `done`, with the new flags and the new accumulator on its outputs.

Top module: `shiftrot_flag_unit`

## Requirements
- R1: Op code 0 rotates left, feeding bit 7 into bit 0 and into carry. Op code 1 rotates right, feeding bit 0 into bit 7 and into carry.
- R2: Op code 2 shifts left, taking the old carry into bit 0 and putting the old bit 7 into carry. Op code 3 shifts right, taking the old carry into bit 7 and putting the old bit 0 into carry.
- R3: Op code 4 shifts left with zero into bit 0 and bit 7 into carry. Op code 5 shifts right, keeping bit 7 and sending bit 0 to carry. Op code 6 shifts right with zero into bit 7 and bit 0 to carry.
- R4: The flag byte has sign at bit 7, zero at 6, X at 5, half-carry at 4, parity at 2, subtract at 1 and carry at 0. Ops 0 to 6 clear half-carry and subtract, set carry from the bit shifted out, and keep bits 5 and 3.
- R5: When `full_flags` is 1, ops 0 to 6 set sign from result bit 7, set zero when the result is 0, and set parity to 1 when the result has an even number of ones.
- R6: When `full_flags` is 0 on a register operation, sign, zero and parity keep their incoming values.
- R7: A register operation (`mem_mode`=0, op 0 to 6) has `result`, `flags_out` and `done` valid in the cycle after the `start` edge, and `acc_out` equals `acc_in`. `done` lasts one cycle.
- R8: A memory operation raises `mem_rd_req` and holds it until `mem_rd_ack`. It then raises `mem_wr_req` with `mem_wr_data` held stable until `mem_wr_ack`. `done` pulses in the cycle after the write acknowledge. The two requests are never high together.
- R9: Memory operations with ops 0 to 6 always behave as if `full_flags` were 1.
- R10: Op code 8 (nibble exchange left) sets the accumulator low nibble to the memory high nibble. It writes back the memory low nibble in the high half, with the old accumulator low nibble below it. The accumulator high nibble is kept.
- R11: Op code 9 (nibble exchange right) sets the accumulator low nibble to the memory low nibble. It writes back the old accumulator low nibble in the high half and the old memory high nibble in the low half.
- R12: Op codes 8 and 9 always use the memory path. They clear X, half-carry and subtract, set parity from the new accumulator (1 for even ones), and keep carry, sign and zero.
- R13: `start` is ignored while `busy` is 1.
- R14: Op codes 7 and 10 to 15 on a register operand return the operand unchanged, with flags equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 4 | Operation code |
| full_flags | input | 1 | Recompute sign, zero and parity on register operations |
| mem_mode | input | 1 | Operand comes from memory |
| operand | input | 8 | Register operand byte |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | Result byte (the written byte for memory operations) |
| flags_out | output | 8 | New flag byte |
| acc_out | output | 8 | New accumulator |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Memory operation in progress |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 8 | Byte read from memory |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_ack | input | 1 | Write acknowledge |
| mem_wr_data | output | 8 | Byte to be written |

## Verification
A register operation finishes one edge after `start`. The bench drives `start` at a falling edge and samples `done`, `result` and `flags_out` at the next falling edge. On a memory operation the read request is due one edge after `start` and the write request one edge after the read acknowledge. `done` comes one edge after the write acknowledge. The bench varies how long each acknowledge is delayed and samples every stage at the falling edge that follows the edge in question. While waiting, it also checks that the request is still held and that `done` stays low.

// File: rtl/shiftrot_flag_unit.sv
module shiftrot_flag_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic         full_flags,
  input  logic         mem_mode,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] flags_in,
  output logic [W-1:0] result,
  output logic [W-1:0] flags_out,
  output logic [W-1:0] acc_out,
  output logic         done,
  output logic         busy,
  output logic         mem_rd_req,
  input  logic         mem_rd_ack,
  input  logic [W-1:0] mem_rd_data,
  output logic         mem_wr_req,
  input  logic         mem_wr_ack,
  output logic [W-1:0] mem_wr_data
);
  localparam int FS = 7, FZ = 6, FX = 5, FH = 4, FP = 2, FN = 1, FC = 0;
  localparam int HN = W / 2;

  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;

  logic [3:0]   op_q;
  logic [W-1:0] acc_q, flg_q, nflg_q, nacc_q;
  logic [3:0]   c_op;
  logic [W-1:0] c_d, c_a, c_f, c_res, c_flg, c_acc;
  logic         c_full, c_out, go_mem;

  assign go_mem     = mem_mode || op == 4'd8 || op == 4'd9;
  assign busy       = st != IDLE;
  assign mem_rd_req = st == RD;
  assign mem_wr_req = st == WR;

  assign c_op   = (st == IDLE) ? op : op_q;
  assign c_a    = (st == IDLE) ? acc_in : acc_q;
  assign c_f    = (st == IDLE) ? flags_in : flg_q;
  assign c_d    = (st == RD) ? mem_rd_data : operand;
  assign c_full = (st == IDLE) ? full_flags : 1'b1;

  always_comb begin
    c_res = c_d;
    c_out = c_f[FC];
    c_flg = c_f;
    c_acc = c_a;
    case (c_op)
      4'd0: begin c_res = {c_d[W-2:0], c_d[W-1]};   c_out = c_d[W-1]; end
      4'd1: begin c_res = {c_d[0], c_d[W-1:1]};     c_out = c_d[0];   end
      4'd2: begin c_res = {c_d[W-2:0], c_f[FC]};    c_out = c_d[W-1]; end
      4'd3: begin c_res = {c_f[FC], c_d[W-1:1]};    c_out = c_d[0];   end
      4'd4: begin c_res = {c_d[W-2:0], 1'b0};       c_out = c_d[W-1]; end
      4'd5: begin c_res = {c_d[W-1], c_d[W-1:1]};   c_out = c_d[0];   end
      4'd6: begin c_res = {1'b0, c_d[W-1:1]};       c_out = c_d[0];   end
      4'd8: begin
        c_acc = {c_a[W-1:HN], c_d[W-1:HN]};
        c_res = {c_d[HN-1:0], c_a[HN-1:0]};
      end
      4'd9: begin
        c_acc = {c_a[W-1:HN], c_d[HN-1:0]};
        c_res = {c_a[HN-1:0], c_d[W-1:HN]};
      end
      default: ;
    endcase
    if (c_op <= 4'd6) begin
      c_flg[FH] = 1'b0;
      c_flg[FN] = 1'b0;
      c_flg[FC] = c_out;
      if (c_full) begin
        c_flg[FS] = c_res[W-1];
        c_flg[FZ] = c_res == '0;
        c_flg[FP] = ~^c_res;
      end
    end else if (c_op == 4'd8 || c_op == 4'd9) begin
      c_flg[FX] = 1'b0;
      c_flg[FH] = 1'b0;
      c_flg[FN] = 1'b0;
      c_flg[FP] = ~^c_acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      done <= 1'b0;
      op_q <= '0; acc_q <= '0; flg_q <= '0; nflg_q <= '0; nacc_q <= '0;
      result <= '0; flags_out <= '0; acc_out <= '0; mem_wr_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          if (go_mem) begin
            st <= RD;
            op_q <= op; acc_q <= acc_in; flg_q <= flags_in;
          end else begin
            result <= c_res; flags_out <= c_flg; acc_out <= acc_in;
            done <= 1'b1;
          end
        end
        RD: if (mem_rd_ack) begin
          st <= WR;
          mem_wr_data <= c_res; nflg_q <= c_flg; nacc_q <= c_acc;
        end
        WR: if (mem_wr_ack) begin
          st <= IDLE;
          result <= mem_wr_data; flags_out <= nflg_q; acc_out <= nacc_q;
          done <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module shiftrot_flag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [3:0] op,
  input logic       mem_mode,
  input logic       busy,
  input logic       done,
  input logic       mem_rd_req,
  input logic       mem_rd_ack,
  input logic       mem_wr_req,
  input logic       mem_wr_ack,
  input logic [7:0] mem_wr_data
);
  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req);
  // R8
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_ack |=> mem_wr_req && !mem_rd_req);
  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_data));
  // R8
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && mem_wr_ack |=> done && !busy);
  // R7
  reg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !mem_mode && op <= 4'd6 |=> done && !busy);
  // R13
  busy_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind shiftrot_flag_unit shiftrot_flag_chk u_chk (.*);

// File: tb/shiftrot_flag_unit_bench.sv
module shiftrot_flag_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, full_flags = 0, mem_mode = 0, mem_rd_ack = 0, mem_wr_ack = 0;
  logic [3:0] op = '0;
  logic [7:0] operand = '0, acc_in = '0, flags_in = '0, mem_rd_data = '0;
  logic [7:0] result, flags_out, acc_out, mem_wr_data;
  logic done, busy, mem_rd_req, mem_wr_req;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shiftrot_flag_unit u_shiftrot_flag_unit (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit evenp(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return (n % 2) == 0;
  endfunction

  // returns {written/result byte, flags, accumulator}
  function automatic logic [23:0] model(input int o, input bit full, input logic [7:0] d,
                                        input logic [7:0] a, input logic [7:0] f);
    logic [7:0] r = d, nf = f, na = a;
    bit co = 0;
    if (o <= 6) begin
      case (o)
        0: begin r = (d << 1) | (d >> 7);      co = d[7]; end
        1: begin r = (d >> 1) | (d << 7);      co = d[0]; end
        2: begin r = (d << 1) | 8'(f[0]);      co = d[7]; end
        3: begin r = (d >> 1) | (f[0] ? 8'h80 : 8'h00); co = d[0]; end
        4: begin r = d << 1;                   co = d[7]; end
        5: begin r = (d >> 1) | (d & 8'h80);   co = d[0]; end
        default: begin r = d >> 1;             co = d[0]; end
      endcase
      nf = (f & ~8'h13) | 8'(co);
      if (full) begin
        nf = nf & ~8'hC4;
        if (r[7]) nf |= 8'h80;
        if (r == 0) nf |= 8'h40;
        if (evenp(r)) nf |= 8'h04;
      end
    end else if (o == 8) begin
      na = (a & 8'hF0) | (d >> 4);
      r = (d << 4) | (a & 8'h0F);
      nf = (f & ~8'h36) | (evenp(na) ? 8'h04 : 8'h00);
    end else if (o == 9) begin
      na = (a & 8'hF0) | (d & 8'h0F);
      r = (a << 4) | (d >> 4);
      nf = (f & ~8'h36) | (evenp(na) ? 8'h04 : 8'h00);
    end
    return {r, nf, na};
  endfunction

  task automatic reg_op(input int o, input bit full, input logic [7:0] d,
                        input logic [7:0] a, input logic [7:0] f, input string req);
    logic [23:0] e = model(o, full, d, a, f);
    @(negedge clk);
    start = 1; op = 4'(o); full_flags = full; mem_mode = 0;
    operand = d; acc_in = a; flags_in = f;
    @(negedge clk);
    start = 0;
    chk(done && result == e[23:16] && flags_out == e[15:8] && acc_out == a, req,
        $sformatf("op%0d d=%h f=%h done,res,flg,acc", o, d, f),
        {done, result, flags_out, acc_out}, {1'b1, e[23:16], e[15:8], a});
  endtask

  task automatic mem_op(input int o, input bit full, input logic [7:0] d,
                        input logic [7:0] a, input logic [7:0] f, input int lat,
                        input bit inject, input string req);
    logic [23:0] e = model(o, 1'b1, d, a, f);
    @(negedge clk);
    start = 1; op = 4'(o); full_flags = full; mem_mode = 1;
    operand = ~d; acc_in = a; flags_in = f;
    @(negedge clk);
    start = 0; operand = 8'h00; acc_in = ~a; flags_in = ~f;
    chk(mem_rd_req && !mem_wr_req && busy && !done, "R8", "read request raised",
        {mem_rd_req, mem_wr_req, busy, done}, 4'b1010);
    for (int i = 0; i < lat; i++) begin
      if (inject && i == 0) begin start = 1; op = 4'd0; mem_mode = 0; end
      @(negedge clk);
      start = 0;
      chk(mem_rd_req && !done, inject ? "R13" : "R8", "read request held",
          {mem_rd_req, done}, 2'b10);
    end
    mem_rd_ack = 1; mem_rd_data = d;
    @(negedge clk);
    mem_rd_ack = 0; mem_rd_data = 8'hXX;
    chk(mem_wr_req && !mem_rd_req && mem_wr_data == e[23:16], req, "write request and data",
        {mem_wr_req, mem_rd_req, mem_wr_data}, {2'b10, e[23:16]});
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_wr_req && !done && mem_wr_data == e[23:16], "R8", "write held",
          {mem_wr_req, done, mem_wr_data}, {2'b10, e[23:16]});
    end
    mem_wr_ack = 1;
    @(negedge clk);
    mem_wr_ack = 0;
    chk(done && !mem_wr_req && !busy && flags_out == e[15:8] && acc_out == e[7:0]
        && result == e[23:16], req, $sformatf("op%0d d=%h done,flg,acc,res", o, d),
        {done, busy, flags_out, acc_out, result}, {2'b10, e[15:8], e[7:0], e[23:16]});
    @(negedge clk);
    chk(!done && !mem_rd_req, "R8", "single done pulse", {done, mem_rd_req}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!done && !busy && !mem_rd_req && !mem_wr_req && result == 0 && flags_out == 0,
        "R7", "reset state", {done, busy, mem_rd_req, mem_wr_req, result, flags_out},
        20'h0);

    for (int o = 0; o <= 6; o++)
      for (int d = 0; d < 256; d++)
        for (int k = 0; k < 4; k++) begin
          logic [7:0] dv = 8'(d);
          logic [7:0] fv = {dv[2], dv[5], dv[0], dv[7], dv[4], dv[6], dv[1], k[0]};
          string rq = (o < 2) ? "R1" : (o < 4) ? "R2" : "R3";
          if (k[1] == 0) rq = {rq, "/R6"}; else rq = {rq, "/R4/R5"};
          reg_op(o, k[1], dv, dv ^ 8'h5A, fv, rq);
        end
    @(negedge clk);
    chk(!done, "R7", "done lasts one cycle", done, 0);

    foreach (op[i]) ;
    for (int o = 7; o <= 15; o++) begin
      if (o == 8 || o == 9) continue;
      for (int d = 0; d < 256; d += 17) reg_op(o, 1'b1, 8'(d), 8'h33, 8'(d * 5 + o), "R14");
    end

    for (int o = 8; o <= 9; o++)
      for (int d = 0; d < 256; d++)
        for (int a = 0; a < 4; a++) begin
          logic [7:0] av = (a == 0) ? 8'h00 : (a == 1) ? 8'hA5 : (a == 2) ? 8'h3C : 8'hFF;
          mem_op(o, 1'b0, 8'(d), av, ~8'(d) ^ 8'(a), (d + a) % 3, 1'b0,
                 o == 8 ? "R10/R12" : "R11/R12");
        end

    for (int o = 0; o <= 6; o++)
      for (int d = 0; d < 256; d += 7)
        mem_op(o, 1'b0, 8'(d), 8'h96, 8'(d * 3) & 8'h3B, d % 4, 1'b0, "R9");

    mem_op(2, 1'b0, 8'h81, 8'h11, 8'h01, 3, 1'b1, "R13");
    mem_op(8, 1'b1, 8'h7E, 8'hC3, 8'hFF, 2, 1'b1, "R13");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule